// File: doc/BRIEF.md
# Flash command decoder with identification mode

This block is the byte-wide command front end of a small parallel flash array model. It watches the active-low chip-enable, output-enable and write-enable strobes together with the address and data buses. It turns each accepted write into a command byte and keeps track of the device mode: plain read, identification, or a pending erase or program setup. The strobes arrive asynchronously. They pass through two-flop synchronisers, and a write is recognised when its synchronised pulse ends.

Erase and program each need a setup byte followed by the matching execute byte. Only then does the block raise a one-cycle request, with the address of the execute write, towards the neighbouring array controller. Identification mode returns fixed bytes on the read data port. The neighbouring array logic uses `id_active` to choose between these bytes and array data. A neighbouring protection block can block all writes through `inhibit`.

Command bytes (the default parameters): identification 90H, erase setup 20H, erase execute D0H, program setup 40H, program execute 10H, reset FFH.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the block is in read mode: `id_active`, `erase_req` and `prog_req` are 0 and `dout` is 00H.
- R2: An accepted write of byte 90H from read mode enters identification mode, and `id_active` is then 1.
- R3: In identification mode, `dout` is BFH for address 0, 04H for address 1 and 00H for every other address. Outside identification mode `dout` is 00H.
- R4: In identification mode a write of 20H, 40H or FFH leaves the mode. Every other byte, including 90H, D0H and 10H, leaves the block in identification mode.
- R5: Byte 20H followed by byte D0H raises `erase_req` for exactly one cycle. `req_addr` then holds the address of the D0H write, and the block returns to read mode.
- R6: Byte 40H followed by byte 10H raises `prog_req` for exactly one cycle. `req_addr` then holds the address of the 10H write, and the block returns to read mode.
- R7: A lone D0H or 10H written in read mode raises no request and leaves the block in read mode.
- R8: After a setup byte, any byte other than its own execute byte returns the block to read mode with no request. This includes 90H and the execute byte of the other operation.
- R9: Byte FFH returns the block to read mode from every state.
- R10: A write has no effect if, while it is in progress, output-enable is low, chip-enable is high (so CE and WE are never low together) or `inhibit` is high.
- R11: A write-enable pulse shorter than MIN_PULSE synchronised clock cycles is rejected. A pulse of MIN_PULSE cycles or longer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | AW | Address bus |
| din | input | 8 | Write data bus (command byte) |
| inhibit | input | 1 | Write block from the protection logic |
| dout | output | 8 | Identification read data |
| id_active | output | 1 | Identification mode is active |
| erase_req | output | 1 | One-cycle erase request |
| prog_req | output | 1 | One-cycle program request |
| req_addr | output | AW | Address of the execute write that raised the last request |

## Verification
The bench puts the decoder into each of its four modes and writes every one of the 256 byte values. After each byte it sends one execute byte as a probe. This exposes a design that misses setup states, runs a lone execute byte, keeps a setup pending after a foreign byte, or leaves identification mode on a byte that should not end it. The bench sweeps write-enable widths across the glitch threshold. A design with an off-by-one in its pulse counter would accept a too-short pulse or drop a pulse of exactly the minimum width. Writes are also attempted with output-enable low, with chip-enable high and with `inhibit` raised. Any of these that still changes the mode shows up at `id_active`. Identification reads over the low addresses catch wrong codes or a code returned outside address 0 and 1.

// File: rtl/flash_cmd_front.sv
module flash_cmd_front #(
  parameter int AW        = 19,
  parameter int MIN_PULSE = 1,
  parameter logic [7:0] C_ID  = 8'h90,
  parameter logic [7:0] C_ES  = 8'h20,
  parameter logic [7:0] C_EX  = 8'hD0,
  parameter logic [7:0] C_PS  = 8'h40,
  parameter logic [7:0] C_PX  = 8'h10,
  parameter logic [7:0] C_RST = 8'hFF,
  parameter logic [7:0] MAKER = 8'hBF,
  parameter logic [7:0] PART  = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          inhibit,
  output logic [7:0]    dout,
  output logic          id_active,
  output logic          erase_req,
  output logic          prog_req,
  output logic [AW-1:0] req_addr
);
  localparam int CW = $clog2(MIN_PULSE + 1) + 1;

  typedef enum logic [1:0] {S_READ, S_ID, S_ERS, S_PRG} st_t;

  logic [1:0]    ce_q, oe_q, we_q;
  logic          act, act_q, commit;
  logic [CW-1:0] cnt;
  logic [AW-1:0] cap_a;
  logic [7:0]    cap_d;
  st_t           st, st_nx;
  logic          ers_nx, prg_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_q <= 2'b11;
      oe_q <= 2'b11;
      we_q <= 2'b11;
    end else begin
      ce_q <= {ce_q[0], ce_n};
      oe_q <= {oe_q[0], oe_n};
      we_q <= {we_q[0], we_n};
    end

  assign act    = ~ce_q[1] & ~we_q[1] & oe_q[1] & ~inhibit;
  assign commit = act_q & ~act & (cnt >= CW'(MIN_PULSE)) & oe_q[1] & ~inhibit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt   <= '0;
      cap_a <= '0;
      cap_d <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        if (cnt != '1) cnt <= cnt + 1'b1;
        cap_a <= addr;
        cap_d <= din;
      end else begin
        cnt <= '0;
      end
    end

  always_comb begin
    st_nx  = st;
    ers_nx = 1'b0;
    prg_nx = 1'b0;
    if (commit) begin
      if (cap_d == C_RST) st_nx = S_READ;
      else case (st)
        S_READ, S_ID: begin
          if (cap_d == C_ES)      st_nx = S_ERS;
          else if (cap_d == C_PS) st_nx = S_PRG;
          else if (cap_d == C_ID) st_nx = S_ID;
        end
        S_ERS: begin
          st_nx  = S_READ;
          ers_nx = (cap_d == C_EX);
        end
        default: begin
          st_nx  = S_READ;
          prg_nx = (cap_d == C_PX);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_READ;
      erase_req <= 1'b0;
      prog_req  <= 1'b0;
      req_addr  <= '0;
    end else begin
      st        <= st_nx;
      erase_req <= ers_nx;
      prog_req  <= prg_nx;
      if (ers_nx | prg_nx) req_addr <= cap_a;
    end

  assign id_active = (st == S_ID);
  assign dout = !id_active          ? 8'h00 :
                (addr == '0)        ? MAKER :
                (addr == AW'(1))    ? PART  : 8'h00;
endmodule

module flash_cmd_front_chk #(parameter int AW = 19) (
  input logic          clk,
  input logic          rst_n,
  input logic          inhibit,
  input logic [1:0]    st,
  input logic [7:0]    dout,
  input logic          id_active,
  input logic          erase_req,
  input logic          prog_req
);
  // R5
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  // R5
  erase_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(st) == 2'd2 && st == 2'd0);
  // R6
  prog_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(st) == 2'd3 && st == 2'd0);
  // R6
  no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_req && prog_req));
  // R10
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> $stable(st) && !erase_req && !prog_req);
  // R3
  id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_active |-> dout == 8'h00);
endmodule

bind flash_cmd_front flash_cmd_front_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .st(st), .dout(dout),
  .id_active(id_active), .erase_req(erase_req), .prog_req(prog_req));

// File: tb/sim_flash_cmd_front.sv
module sim_flash_cmd_front;
  localparam int AW = 12;
  localparam int MP = 3;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, inhibit = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic id_active, erase_req, prog_req;
  logic [AW-1:0] req_addr;
  int errors = 0, checks = 0, n_ers = 0, n_prg = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_cmd_front #(.AW(AW), .MIN_PULSE(MP)) u0 (.*);

  always @(posedge clk) begin
    if (erase_req) n_ers++;
    if (prog_req)  n_prg++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [AW-1:0] a, input logic [7:0] d,
                        input int w, input logic cev, input logic oev);
    @(negedge clk);
    addr = a; din = d; ce_n = cev; we_n = 0; oe_n = oev;
    repeat (w) @(negedge clk);
    we_n = 1; ce_n = 1; oe_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    strobe(a, d, MP, 1'b0, 1'b1);
  endtask

  // model states: 0 read, 1 id, 2 erase setup, 3 program setup
  function automatic int nxt(input int s, input logic [7:0] b, output bit e, output bit p);
    e = 0; p = 0;
    if (b == 8'hFF) return 0;
    case (s)
      0, 1: begin
        if (b == 8'h20) return 2;
        if (b == 8'h40) return 3;
        if (b == 8'h90) return 1;
        return s;
      end
      2: begin e = (b == 8'hD0); return 0; end
      default: begin p = (b == 8'h10); return 0; end
    endcase
  endfunction

  task automatic enter(input int s);
    wr('0, 8'hFF);
    if (s == 1) wr('0, 8'h90);
    if (s == 2) wr('0, 8'h20);
    if (s == 3) wr('0, 8'h40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e0, p0, s2;
    bit e, p, e2, p2;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!id_active && !erase_req && !prog_req && dout == 8'h00, "R1 reset", {id_active, erase_req, prog_req}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!id_active && dout == 8'h00, "R1 after release", id_active, 0);

    // R2 enter id, R3 id reads
    wr('0, 8'h90);
    chk(id_active, "R2 id entry", id_active, 1);
    for (int a = 0; a < 16; a++) begin
      addr = AW'(a); #1;
      chk(dout == (a == 0 ? 8'hBF : a == 1 ? 8'h04 : 8'h00), "R3 id read", dout, a == 0 ? 8'hBF : a == 1 ? 8'h04 : 8'h00);
    end
    // R9 reset command leaves id, R3 quiet outside id
    wr('0, 8'hFF);
    addr = '0; #1;
    chk(!id_active && dout == 8'h00, "R9 R3 exit and quiet", dout, 0);

    // R5 and R6 direct, req_addr
    e0 = n_ers;
    wr(AW'(12'h3A5), 8'h20); wr(AW'(12'h5C3), 8'hD0);
    chk(n_ers == e0 + 1, "R5 erase count", n_ers - e0, 1);
    chk(req_addr == AW'(12'h5C3), "R5 erase address", req_addr, 12'h5C3);
    p0 = n_prg;
    wr(AW'(12'h111), 8'h40); wr(AW'(12'h7E2), 8'h10);
    chk(n_prg == p0 + 1, "R6 program count", n_prg - p0, 1);
    chk(req_addr == AW'(12'h7E2), "R6 program address", req_addr, 12'h7E2);
    // R7 lone execute
    e0 = n_ers; p0 = n_prg;
    wr('0, 8'hD0); wr('0, 8'h10);
    chk(n_ers == e0 && n_prg == p0 && !id_active, "R7 lone execute", n_ers + n_prg - e0 - p0, 0);

    // R11 pulse width sweep
    for (int w = 1; w <= MP + 2; w++) begin
      wr('0, 8'hFF);
      strobe('0, 8'h90, w, 1'b0, 1'b1);
      chk(id_active == (w >= MP), "R11 pulse width", id_active, w >= MP);
    end

    // R10 write gating
    wr('0, 8'hFF);
    strobe('0, 8'h90, MP + 1, 1'b1, 1'b1);
    chk(!id_active, "R10 ce high", id_active, 0);
    strobe('0, 8'h90, MP + 1, 1'b0, 1'b0);
    chk(!id_active, "R10 oe low", id_active, 0);
    inhibit = 1;
    strobe('0, 8'h90, MP + 1, 1'b0, 1'b1);
    inhibit = 0;
    chk(!id_active, "R10 inhibit", id_active, 0);
    wr('0, 8'h20);
    inhibit = 1; e0 = n_ers;
    strobe('0, 8'hD0, MP + 1, 1'b0, 1'b1);
    inhibit = 0;
    chk(n_ers == e0, "R10 inhibit execute", n_ers - e0, 0);

    // R4 R8 R9 exhaustive: every state, every byte, two probes
    for (int pr = 0; pr < 2; pr++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 256; b++) begin
          logic [7:0] pb;
          pb = pr ? 8'h10 : 8'hD0;
          enter(s);
          e0 = n_ers; p0 = n_prg;
          wr(AW'({b[7:0], 4'h5}), b[7:0]);
          s2 = nxt(s, b[7:0], e, p);
          chk(id_active == (s2 == 1) && n_ers - e0 == int'(e) && n_prg - p0 == int'(p),
              "R4 R8 R9 sweep step", {s, b, id_active, n_ers - e0, n_prg - p0}, {s, b, s2 == 1, e, p});
          e0 = n_ers; p0 = n_prg;
          wr(AW'(b), pb);
          void'(nxt(s2, pb, e2, p2));
          chk(n_ers - e0 == int'(e2) && n_prg - p0 == int'(p2),
              "R8 probe after byte", {s, b, n_ers - e0, n_prg - p0}, {s, b, e2, p2});
        end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule